// File: doc/BRIEF.md
# Interrupt priority acknowledge controller

This block owns the processor status byte that governs maskable interrupt entry. The byte carries a global enable flag and a two-bit field naming the priority currently in service. Each cycle the block weighs one pending request, tagged with a two-bit level, against that byte. It raises a one-cycle acknowledge when the request may preempt what is running. On entry it saves the old byte on a small internal last-in, first-out store, drops the enable flag and narrows the in-service field, so that only more urgent levels can nest. Return, pop and break strobes move the byte to and from the same store.

The arithmetic flags and the register-bank selector bits that share the byte are only held here: they change through the byte write port, single-bit set and clear, or a restore. Sequencing is a two-state machine. READY is the resting state; the ACCEPT transition moves it to ACK_OUT when a request is taken. ACK_OUT drives the acknowledge and always leaves by the RELEASE transition back to READY. All other strobes update the byte without leaving READY.

Top module: `irq_ack_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the status byte reads 8'h06 and ack_o, ovf_o and unf_o are 0.
- R2: Bit 7 of the status byte is the enable flag and bits 2:1 are the in-service field. Bits 6, 5, 4, 3 and 0 hold whatever was last written or restored.
- R3: A request is accepted when req_i is 1, the enable flag is 1 and req_lvl_i is no greater than the in-service field. Otherwise it is not acknowledged.
- R4: On acceptance the old byte is pushed, the enable flag is cleared and the in-service field becomes req_lvl_i minus one, floored at 0. ack_o is high for exactly the one cycle after the decision.
- R5: brk_i pushes the byte and clears the enable flag whatever the request state. It takes precedence over acceptance, which then does not occur.
- R6: reti_i, retb_i and pop_i each replace the byte with the most recently stored entry, in last-in, first-out order.
- R7: push_i stores the current byte on the stack without changing it.
- R8: ei_i sets and di_i clears the enable flag. When both are high, di_i wins.
- R9: wr_en_i loads wr_data_i into the whole byte. bset_i sets and bclr_i clears the bit selected by bidx_i. Precedence is write, then set, then clear.
- R10: One action is taken per cycle, in this precedence: break, acceptance, restore, push, disable, enable, write, bit set, bit clear. In particular, acceptance overrides a same-cycle write.
- R11: A push, break or acceptance with 8 entries stored pulses ovf_o in the next cycle and leaves the stored entries unchanged.
- R12: A restore with the stack empty pulses unf_o in the next cycle and leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Maskable request pending |
| req_lvl_i | input | 2 | Level of the pending request (0 most urgent) |
| ei_i | input | 1 | Set the enable flag |
| di_i | input | 1 | Clear the enable flag |
| brk_i | input | 1 | Software break entry |
| reti_i | input | 1 | Return from interrupt (restore) |
| retb_i | input | 1 | Return from break (restore) |
| push_i | input | 1 | Store the byte on the stack |
| pop_i | input | 1 | Restore the byte from the stack |
| wr_en_i | input | 1 | Full byte write enable |
| wr_data_i | input | 8 | Byte write data |
| bset_i | input | 1 | Set one bit |
| bclr_i | input | 1 | Clear one bit |
| bidx_i | input | 3 | Bit index for set or clear |
| ack_o | output | 1 | Acknowledge pulse |
| psw_o | output | 8 | Current status byte |
| ovf_o | output | 1 | Stack overflow pulse |
| unf_o | output | 1 | Stack underflow pulse |

## Verification
The properties assume that every input is driven with a known value on each clock edge. They also assume that req_lvl_i is meaningful whenever req_i is high, so the level seen in the decision cycle is the one that set the in-service field. The bench changes inputs only at the falling edge and returns every strobe to zero after one cycle. Conflicting strobes are raised together only in the dedicated precedence cases.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int PSW_W  = 8;
    localparam int IE_BIT = 7;
    localparam int ISP_HI = 2;
    localparam int ISP_LO = 1;
    localparam logic [PSW_W-1:0] PSW_RESET = 8'h06;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_BRK,
        OP_ACK,
        OP_POP,
        OP_PUSH,
        OP_DI,
        OP_EI,
        OP_WR,
        OP_BSET,
        OP_BCLR
    } op_e;

    typedef enum logic [0:0] {
        ST_READY,
        ST_ACK_OUT
    } ack_state_e;

    function automatic logic [1:0] isp_after(input logic [1:0] lvl);
        return (lvl == 2'd0) ? 2'd0 : lvl - 2'd1;
    endfunction

endpackage

// File: rtl/irq_op_decode.sv
module irq_op_decode
    import irq_ack_pkg::*;
(
    input  logic [PSW_W-1:0] psw_i,
    input  logic             req_i,
    input  logic [1:0]       req_lvl_i,
    input  logic             brk_i,
    input  logic             restore_i,
    input  logic             push_i,
    input  logic             di_i,
    input  logic             ei_i,
    input  logic             wr_en_i,
    input  logic             bset_i,
    input  logic             bclr_i,
    output op_e              op_o
);

    logic accept;

    // A level is allowed when it is no less urgent than the in-service field.
    assign accept = req_i && psw_i[IE_BIT] && (req_lvl_i <= psw_i[ISP_HI:ISP_LO]);

    always_comb begin
        if (brk_i)          op_o = OP_BRK;
        else if (accept)    op_o = OP_ACK;
        else if (restore_i) op_o = OP_POP;
        else if (push_i)    op_o = OP_PUSH;
        else if (di_i)      op_o = OP_DI;
        else if (ei_i)      op_o = OP_EI;
        else if (wr_en_i)   op_o = OP_WR;
        else if (bset_i)    op_o = OP_BSET;
        else if (bclr_i)    op_o = OP_BCLR;
        else                op_o = OP_NONE;
    end

endmodule

// File: rtl/psw_lifo.sv
module psw_lifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] top_o,
    output logic          full_o,
    output logic          empty_o
);

    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SPW = $clog2(DEPTH + 1);

    logic [DW-1:0]  mem_q [DEPTH];
    logic [SPW-1:0] sp_q;

    assign full_o  = (sp_q == SPW'(DEPTH));
    assign empty_o = (sp_q == '0);
    assign top_o   = empty_o ? '0 : mem_q[AW'(sp_q - SPW'(1))];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sp_q <= '0;
        end else if (push_i && !full_o) begin
            sp_q <= sp_q + SPW'(1);
        end else if (pop_i && !empty_o) begin
            sp_q <= sp_q - SPW'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                mem_q[g] <= '0;
            end else if (push_i && !full_o && (sp_q == SPW'(g))) begin
                mem_q[g] <= din_i;
            end
        end
    end

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int STACK_DEPTH = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       req_i,
    input  logic [1:0] req_lvl_i,
    input  logic       ei_i,
    input  logic       di_i,
    input  logic       brk_i,
    input  logic       reti_i,
    input  logic       retb_i,
    input  logic       push_i,
    input  logic       pop_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       bset_i,
    input  logic       bclr_i,
    input  logic [2:0] bidx_i,
    output logic       ack_o,
    output logic [7:0] psw_o,
    output logic       ovf_o,
    output logic       unf_o
);

    op_e              op;
    ack_state_e       state_q, state_d;
    logic [PSW_W-1:0] psw_q, psw_d;
    logic [PSW_W-1:0] stk_top;
    logic             stk_push, stk_pop, stk_full, stk_empty;
    logic             ovf_q, ovf_d, unf_q, unf_d;

    irq_op_decode u_decode (
        .psw_i     (psw_q),
        .req_i     (req_i),
        .req_lvl_i (req_lvl_i),
        .brk_i     (brk_i),
        .restore_i (reti_i | retb_i | pop_i),
        .push_i    (push_i),
        .di_i      (di_i),
        .ei_i      (ei_i),
        .wr_en_i   (wr_en_i),
        .bset_i    (bset_i),
        .bclr_i    (bclr_i),
        .op_o      (op)
    );

    psw_lifo #(
        .DEPTH (STACK_DEPTH),
        .DW    (PSW_W)
    ) u_stack (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (stk_push),
        .pop_i   (stk_pop),
        .din_i   (psw_q),
        .top_o   (stk_top),
        .full_o  (stk_full),
        .empty_o (stk_empty)
    );

    // Status byte update, one action per cycle.
    always_comb begin
        psw_d    = psw_q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        unique case (op)
            OP_BRK: begin
                stk_push       = 1'b1;
                psw_d[IE_BIT]  = 1'b0;
            end
            OP_ACK: begin
                stk_push                 = 1'b1;
                psw_d[IE_BIT]            = 1'b0;
                psw_d[ISP_HI:ISP_LO]     = isp_after(req_lvl_i);
            end
            OP_POP: begin
                stk_pop = 1'b1;
                if (!stk_empty) psw_d = stk_top;
            end
            OP_PUSH: stk_push           = 1'b1;
            OP_DI:   psw_d[IE_BIT]      = 1'b0;
            OP_EI:   psw_d[IE_BIT]      = 1'b1;
            OP_WR:   psw_d              = wr_data_i;
            OP_BSET: psw_d[bidx_i]      = 1'b1;
            OP_BCLR: psw_d[bidx_i]      = 1'b0;
            OP_NONE: psw_d              = psw_q;
            default: psw_d              = psw_q;
        endcase
        ovf_d = stk_push && stk_full;
        unf_d = stk_pop && stk_empty;
    end

    // Next state: ACCEPT moves to ACK_OUT, RELEASE returns to READY.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:   if (op == OP_ACK) state_d = ST_ACK_OUT;
            ST_ACK_OUT: state_d = ST_READY;
            default:    state_d = ST_READY;
        endcase
    end

    // State and data registers.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_READY;
            psw_q   <= PSW_RESET;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            psw_q   <= psw_d;
            ovf_q   <= ovf_d;
            unf_q   <= unf_d;
        end
    end

    // Outputs.
    always_comb begin
        ack_o = (state_q == ST_ACK_OUT);
        psw_o = psw_q;
        ovf_o = ovf_q;
        unf_o = unf_q;
    end

endmodule

// File: rtl/irq_ack_checker.sv
module irq_ack_checker
    import irq_ack_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       req_i,
    input logic [1:0] req_lvl_i,
    input logic       brk_i,
    input logic       push_i,
    input logic       ack_o,
    input logic [7:0] psw_o,
    input logic       ovf_o,
    input logic       unf_o
);

    p_reset_value_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (psw_o == PSW_RESET && !ack_o && !ovf_o && !unf_o));

    p_ack_cond_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> ($past(req_i) && $past(psw_o[IE_BIT]) && !$past(brk_i)
                   && ($past(req_lvl_i) <= $past(psw_o[ISP_HI:ISP_LO]))));

    p_ack_state_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> (!psw_o[IE_BIT] && psw_o[ISP_HI:ISP_LO] == isp_after($past(req_lvl_i))));

    p_ack_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);

    p_brk_clears_ie_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_i |=> (!psw_o[IE_BIT] && !ack_o));

    p_ovf_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> $past(push_i || brk_i || req_i));

    p_unf_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unf_o |-> (psw_o == $past(psw_o)));

endmodule

bind irq_ack_ctrl irq_ack_checker u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .req_lvl_i (req_lvl_i),
    .brk_i     (brk_i),
    .push_i    (push_i),
    .ack_o     (ack_o),
    .psw_o     (psw_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
);

// File: tb/tb_irq_ack_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ack_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req, ei, di, brk, reti, retb, push, pop, wr_en, bset, bclr;
    logic [1:0] lvl;
    logic [7:0] wr_data;
    logic [2:0] bidx;
    logic       ack, ovf, unf;
    logic [7:0] psw;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_ack_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_lvl_i(lvl),
        .ei_i(ei), .di_i(di), .brk_i(brk), .reti_i(reti), .retb_i(retb),
        .push_i(push), .pop_i(pop), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .bset_i(bset), .bclr_i(bclr), .bidx_i(bidx),
        .ack_o(ack), .psw_o(psw), .ovf_o(ovf), .unf_o(unf)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req = 0; lvl = 0; ei = 0; di = 0; brk = 0; reti = 0; retb = 0;
        push = 0; pop = 0; wr_en = 0; wr_data = 0; bset = 0; bclr = 0; bidx = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic write_psw(input logic [7:0] v);
        wr_en = 1; wr_data = v;
        tick();
    endtask

    function automatic logic [1:0] exp_isp(input int l);
        return (l == 0) ? 2'd0 : 2'(l - 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] w, e;
        bit acc;
        idle();
        @(negedge clk);
        // R1: during reset
        chk("R1 psw in reset", psw, 8'h06);
        chk("R1 flags in reset", {5'b0, ack, ovf, unf}, 8'h00);
        rst_n = 1;
        chk("R1 psw after reset", psw, 8'h06);

        // R3 R4 R2 R6: sweep enable, in-service field, request and level
        for (int ie = 0; ie < 2; ie++)
            for (int isp = 0; isp < 4; isp++)
                for (int rq = 0; rq < 2; rq++)
                    for (int l = 0; l < 4; l++) begin
                        do_reset();
                        w = 8'h50 | 8'(ie << 7) | 8'(isp << 1);
                        write_psw(w);
                        chk("R2 stored byte", psw, w);
                        req = rq[0]; lvl = 2'(l);
                        tick();
                        acc = (rq == 1) && (ie == 1) && (l <= isp);
                        e = acc ? ((w & 8'h79) | {5'b0, exp_isp(l), 1'b0}) : w;
                        chk("R3 ack decision", {7'b0, ack}, {7'b0, acc});
                        chk("R4 psw after decision", psw, e);
                        if (acc) begin
                            reti = 1;
                            tick();
                            chk("R4 ack one cycle", {7'b0, ack}, 8'h00);
                            chk("R6 reti restores", psw, w);
                        end
                    end

        // R7 R6 R11: fill the stack, overflow, unwind in LIFO order
        do_reset();
        for (int k = 0; k < 8; k++) begin
            write_psw(8'(8'h21 + k * 8'h11));
            push = 1;
            tick();
            chk("R7 push keeps byte", psw, 8'(8'h21 + k * 8'h11));
        end
        write_psw(8'hEE);
        push = 1;
        tick();
        chk("R11 overflow pulse", {7'b0, ovf}, 8'h01);
        tick();
        chk("R11 overflow clears", {7'b0, ovf}, 8'h00);
        for (int k = 7; k >= 0; k--) begin
            if (k % 3 == 0) pop = 1; else if (k % 3 == 1) retb = 1; else reti = 1;
            tick();
            chk("R6 LIFO restore", psw, 8'(8'h21 + k * 8'h11));
            chk("R11 contents intact", {7'b0, unf}, 8'h00);
        end
        // R12: restore on empty
        pop = 1;
        tick();
        chk("R12 underflow pulse", {7'b0, unf}, 8'h01);
        chk("R12 psw unchanged", psw, 8'h21);

        // R5: break over an acceptable request, then return from break
        do_reset();
        write_psw(8'h87);
        brk = 1; req = 1; lvl = 0;
        tick();
        chk("R5 brk no ack", {7'b0, ack}, 8'h00);
        chk("R5 brk clears IE", psw, 8'h07);
        retb = 1;
        tick();
        chk("R5 retb restores", psw, 8'h87);
        // R5: break with IE already clear
        write_psw(8'h02);
        brk = 1;
        tick();
        chk("R5 brk when disabled", psw, 8'h02);

        // R8: enable, disable, both
        do_reset();
        ei = 1; tick();
        chk("R8 ei", psw, 8'h86);
        di = 1; tick();
        chk("R8 di", psw, 8'h06);
        ei = 1; tick();
        ei = 1; di = 1; tick();
        chk("R8 di wins", psw, 8'h06);

        // R9: single bit set and clear, and precedence
        do_reset();
        write_psw(8'h00);
        for (int b = 0; b < 8; b++) begin
            bset = 1; bidx = 3'(b); tick();
            chk("R9 bit set", psw, 8'(1 << b));
            bclr = 1; bidx = 3'(b); tick();
            chk("R9 bit clear", psw, 8'h00);
        end
        wr_en = 1; wr_data = 8'h3C; bset = 1; bidx = 0; tick();
        chk("R9 write over set", psw, 8'h3C);
        bset = 1; bclr = 1; bidx = 0; tick();
        chk("R9 set over clear", psw, 8'h3D);

        // R10: acceptance beats a same-cycle write; restore beats push
        do_reset();
        write_psw(8'h86);
        req = 1; lvl = 2; wr_en = 1; wr_data = 8'hFF;
        tick();
        chk("R10 ack over write", {7'b0, ack}, 8'h01);
        chk("R10 psw after ack", psw, 8'h02);
        reti = 1; push = 1;
        tick();
        chk("R10 restore over push", psw, 8'h86);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule